// File: doc/BRIEF.md
# Operating-System Match Timer with Watchdog

This block is a memory-mapped system timer. A free-running up-counter advances by one on every cycle in which the tick-enable input is high. Four match registers are compared against the counter. When the counter steps onto the value held in a channel's match register and that channel's interrupt enable is set, the channel's status bit latches. The channel's interrupt line stays high until software writes a 1 to that status bit.

The last match channel doubles as a watchdog. After software arms the watchdog, a match on that channel produces a single-cycle reset request. The watchdog works whether or not the channel's interrupt is enabled, and it stays armed until the next reset.

Software reaches the block through a word-wide port with a byte address, a write strobe and write data. Writes take effect at the clock edge. Read data is combinational from the address.

Register map, by byte offset:
- `0x00`, `0x04`, `0x08`, `0x0C`: match registers 0 to 3.
- `0x10`: counter.
- `0x14`: status, bit n for channel n.
- `0x18`: watchdog arm, bit 0.
- `0x1C`: interrupt enable, bit n for channel n.

Top module: `os_match_timer`

## Requirements
- R1: After reset, every register reads 0: counter, all match registers, status, interrupt enable and watchdog arm. `irq_o` and `rst_req_o` are low.
- R2: A cycle with `tick_en` high adds 1 to the counter. Writing offset `0x10` loads the low CNT_W bits of `bus_wdata`. When a counter write and a tick fall in the same cycle, the written value wins.
- R3: Suppose interrupt-enable bit n (offset `0x1C`) is set when a tick moves the counter onto match register n. Then status bit n (offset `0x14`, bit n) and `irq_o[n]` are high after that same edge, and not one tick earlier.
- R4: Suppose enable bit n is clear when a tick moves the counter onto match register n. Then status bit n and `irq_o[n]` stay low.
- R5: The interrupt-enable register stores only bits 11:0 of a write, and reads 0 in bits 31:12.
- R6: Writing 1 to status bit n clears it and lowers `irq_o[n]`. A status bit written 0 keeps its value. If a new match sets the bit in the same cycle as a clear, the bit ends set.
- R7: While the watchdog is armed, a tick that moves the counter onto match register 3 raises `rst_req_o` for exactly one cycle, whatever interrupt-enable bit 3 holds. While it is unarmed, `rst_req_o` stays low.
- R8: Writing 1 to bit 0 of offset `0x18` arms the watchdog. A later write of 0 leaves it armed, and it reads back as 1.
- R9: The counter wraps from all ones to 0. A match at 0 is detected after the wrap, and a free-running counter matches a given value once per wrap period.
- R10: Any offset other than the eight listed reads 0, and a write to it changes no register.
- R11: A match register reads back the low CNT_W bits that were written to it, zero-extended. The counter offset returns the live count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Count-advance pulse, one step per high cycle |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq_o | output | NUM_CH | Per-channel interrupt lines, high while the status bit is set |
| rst_req_o | output | 1 | One-cycle system reset request from the watchdog channel |

## Verification
The bench builds the timer with an 8-bit counter, keeping the four channels and the 8-bit address. The short counter makes every possible match value reachable. The bench sweeps all 256 values across the channels, and for each one checks both the tick before the match and the matching tick. The short counter also makes wrap-around cheap to reach, so the bench lets the counter run through two full periods and counts the matches it sees.

// File: rtl/otm_pkg.sv
package otm_pkg;
  localparam int BUS_W = 32;
  localparam int IE_BITS = 12;
  localparam logic [7:0] OFF_MATCH0 = 8'h00;
  localparam logic [7:0] OFF_COUNT  = 8'h10;
  localparam logic [7:0] OFF_STATUS = 8'h14;
  localparam logic [7:0] OFF_WDOG   = 8'h18;
  localparam logic [7:0] OFF_IE     = 8'h1C;
  localparam int MATCH_STRIDE = 4;
endpackage

// File: rtl/otm_counter.sv
module otm_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             load_en,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] count_q,
  output logic             step,
  output logic [CNT_W-1:0] count_next
);
  // Modular increment: the all-ones value rolls over to zero.
  function automatic logic [CNT_W-1:0] advance(input logic [CNT_W-1:0] c);
    return c + CNT_W'(1);
  endfunction

  // A load in the same cycle suppresses the tick, so no match is seen then.
  assign step       = tick_en && !load_en;
  assign count_next = advance(count_q);

  always_ff @(posedge clk) begin
    if (!rst_n)       count_q <= '0;
    else if (load_en) count_q <= load_val;
    else if (tick_en) count_q <= count_next;
  end
endmodule

// File: rtl/otm_channel.sv
module otm_channel #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             match_wr,
  input  logic [CNT_W-1:0] match_val,
  input  logic             step,
  input  logic [CNT_W-1:0] count_next,
  input  logic             irq_en,
  input  logic             clr_req,
  output logic [CNT_W-1:0] match_q,
  output logic             hit,
  output logic             status_q
);
  function automatic logic is_match(input logic [CNT_W-1:0] a,
                                    input logic [CNT_W-1:0] b);
    return a == b;
  endfunction

  // Event: the counter is stepping onto this channel's value at this edge.
  assign hit = step && is_match(count_next, match_q);

  always_ff @(posedge clk) begin
    if (!rst_n)        match_q <= '0;
    else if (match_wr) match_q <= match_val;
  end

  // A fresh enabled match outranks a software clear in the same cycle.
  always_ff @(posedge clk) begin
    if (!rst_n)              status_q <= 1'b0;
    else if (hit && irq_en)  status_q <= 1'b1;
    else if (clr_req)        status_q <= 1'b0;
  end
endmodule

// File: rtl/otm_watchdog.sv
module otm_watchdog (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_wr,
  input  logic arm_val,
  input  logic wd_hit,
  output logic armed_q,
  output logic rst_req_q
);
  // Arm bit can only be set; only reset returns it to zero.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed_q   <= 1'b0;
      rst_req_q <= 1'b0;
    end else begin
      armed_q   <= armed_q | (arm_wr & arm_val);
      rst_req_q <= armed_q & wd_hit;
    end
  end
endmodule

// File: rtl/os_match_timer.sv
module os_match_timer #(
  parameter int CNT_W  = 32,
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     tick_en,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic                     bus_wr,
  input  logic [otm_pkg::BUS_W-1:0] bus_wdata,
  output logic [otm_pkg::BUS_W-1:0] bus_rdata,
  output logic [NUM_CH-1:0]        irq_o,
  output logic                     rst_req_o
);
  import otm_pkg::*;

  localparam int IE_W   = IE_BITS;
  localparam int WD_CH  = NUM_CH - 1;
  localparam logic [ADDR_W-1:0] A_COUNT  = ADDR_W'(OFF_COUNT);
  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFF_STATUS);
  localparam logic [ADDR_W-1:0] A_WDOG   = ADDR_W'(OFF_WDOG);
  localparam logic [ADDR_W-1:0] A_IE     = ADDR_W'(OFF_IE);

  // Named internal events, visible to the bound checker.
  logic                 cnt_wr;
  logic                 stat_wr;
  logic                 wdog_wr;
  logic                 ie_wr;
  logic                 step;
  logic [CNT_W-1:0]     count_q;
  logic [CNT_W-1:0]     count_next;
  logic [NUM_CH-1:0]    hit_vec;
  logic [NUM_CH-1:0]    status_q;
  logic [NUM_CH-1:0]    stat_clr;
  logic [NUM_CH-1:0]    match_sel;
  logic [IE_W-1:0]      ie_q;
  logic                 wdog_en_q;
  logic                 rst_req_q;
  logic                 addr_mapped;
  logic [CNT_W-1:0]     match_arr [NUM_CH];

  assign cnt_wr   = bus_wr && (bus_addr == A_COUNT);
  assign stat_wr  = bus_wr && (bus_addr == A_STATUS);
  assign wdog_wr  = bus_wr && (bus_addr == A_WDOG);
  assign ie_wr    = bus_wr && (bus_addr == A_IE);
  assign stat_clr = stat_wr ? bus_wdata[NUM_CH-1:0] : '0;

  otm_counter #(.CNT_W(CNT_W)) u_counter (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_en    (tick_en),
    .load_en    (cnt_wr),
    .load_val   (bus_wdata[CNT_W-1:0]),
    .count_q    (count_q),
    .step       (step),
    .count_next (count_next)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    localparam logic [ADDR_W-1:0] A_MATCH = ADDR_W'(OFF_MATCH0) + ADDR_W'(MATCH_STRIDE * i);
    assign match_sel[i] = (bus_addr == A_MATCH);

    otm_channel #(.CNT_W(CNT_W)) u_chan (
      .clk        (clk),
      .rst_n      (rst_n),
      .match_wr   (bus_wr && match_sel[i]),
      .match_val  (bus_wdata[CNT_W-1:0]),
      .step       (step),
      .count_next (count_next),
      .irq_en     (ie_q[i]),
      .clr_req    (stat_clr[i]),
      .match_q    (match_arr[i]),
      .hit        (hit_vec[i]),
      .status_q   (status_q[i])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     ie_q <= '0;
    else if (ie_wr) ie_q <= bus_wdata[IE_W-1:0];
  end

  otm_watchdog u_wdog (
    .clk       (clk),
    .rst_n     (rst_n),
    .arm_wr    (wdog_wr),
    .arm_val   (bus_wdata[0]),
    .wd_hit    (hit_vec[WD_CH]),
    .armed_q   (wdog_en_q),
    .rst_req_q (rst_req_q)
  );

  assign addr_mapped = (|match_sel) || (bus_addr == A_COUNT) || (bus_addr == A_STATUS)
                    || (bus_addr == A_WDOG) || (bus_addr == A_IE);

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == A_COUNT)  bus_rdata = BUS_W'(count_q);
    if (bus_addr == A_STATUS) bus_rdata = BUS_W'(status_q);
    if (bus_addr == A_WDOG)   bus_rdata = BUS_W'(wdog_en_q);
    if (bus_addr == A_IE)     bus_rdata = BUS_W'(ie_q);
    for (int k = 0; k < NUM_CH; k++) begin
      if (match_sel[k]) bus_rdata = BUS_W'(match_arr[k]);
    end
  end

  assign irq_o     = status_q;
  assign rst_req_o = rst_req_q;
endmodule

// File: rtl/otm_checker.sv
module otm_checker #(
  parameter int CNT_W  = 32,
  parameter int NUM_CH = 4,
  parameter int IE_W   = 12,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              step,
  input logic              cnt_wr,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [CNT_W-1:0]  count_q,
  input logic [NUM_CH-1:0] hit_vec,
  input logic [NUM_CH-1:0] stat_clr,
  input logic [IE_W-1:0]   ie_q,
  input logic [NUM_CH-1:0] irq_o,
  input logic              wdog_en_q,
  input logic              rst_req_o,
  input logic              addr_mapped
);
  localparam logic [ADDR_W-1:0] A_IE = ADDR_W'(otm_pkg::OFF_IE);

  assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> count_q == $past(count_q) + CNT_W'(1));

  assert_count_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> count_q == $past(bus_wdata[CNT_W-1:0]));

  assert_enabled_match_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((hit_vec & ie_q[NUM_CH-1:0]) != '0) |=>
      ((irq_o & $past(hit_vec & ie_q[NUM_CH-1:0])) == $past(hit_vec & ie_q[NUM_CH-1:0])));

  assert_no_rise_when_disabled_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_o & ~$past(irq_o) & ~$past(ie_q[NUM_CH-1:0])) == '0));

  assert_ie_upper_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == A_IE) |-> (bus_rdata[31:IE_W] == '0));

  assert_status_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat_clr & ~hit_vec) != '0) |=> ((irq_o & $past(stat_clr & ~hit_vec)) == '0));

  assert_reset_req_on_match_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wdog_en_q && hit_vec[NUM_CH-1]) |=> rst_req_o);

  assert_reset_req_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_o |=> !rst_req_o);

  assert_wdog_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wdog_en_q |=> wdog_en_q);

  assert_wrap_to_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (step && (&count_q)) |=> (count_q == '0));

  assert_unmapped_reads_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_mapped |-> (bus_rdata == '0));
endmodule

bind os_match_timer otm_checker #(
  .CNT_W(CNT_W), .NUM_CH(NUM_CH), .IE_W(IE_W), .ADDR_W(ADDR_W)
) u_otm_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .step        (step),
  .cnt_wr      (cnt_wr),
  .bus_wdata   (bus_wdata),
  .bus_rdata   (bus_rdata),
  .bus_addr    (bus_addr),
  .count_q     (count_q),
  .hit_vec     (hit_vec),
  .stat_clr    (stat_clr),
  .ie_q        (ie_q),
  .irq_o       (irq_o),
  .wdog_en_q   (wdog_en_q),
  .rst_req_o   (rst_req_o),
  .addr_mapped (addr_mapped)
);

// File: tb/tb_os_match_timer.sv
`timescale 1ns/1ps
module tb_os_match_timer;
  localparam int CW = 8;
  localparam int NC = 4;
  localparam int AW = 8;
  localparam logic [7:0] A_CNT = 8'h10, A_ST = 8'h14, A_WD = 8'h18, A_IE = 8'h1C;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick_en = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_wr = 1'b0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NC-1:0] irq_o;
  logic          rst_req_o;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  os_match_timer #(.CNT_W(CW), .NUM_CH(NC), .ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o), .rst_req_o(rst_req_o)
  );

  always #2.5 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic tick();
    @(negedge clk);
    tick_en = 1'b1;
    @(negedge clk);
    tick_en = 1'b0;
  endtask

  initial begin
    #750000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int seen;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state of every register and output
    foreach (A_LIST[i]) begin
      rd(A_LIST[i], v);
      check("R1 reset register", v, 0);
    end
    check("R1 irq_o at reset", 32'(irq_o), 0);
    check("R1 rst_req_o at reset", 32'(rst_req_o), 0);

    // R11: match readback is the low CW bits
    wr(8'h08, 32'h1234_56AB);
    rd(8'h08, v); check("R11 match readback", v, 32'hAB);
    // R2 / R11: live count
    wr(A_CNT, 3); tick(); tick();
    rd(A_CNT, v); check("R2 count after two ticks", v, 5);
    // R2: write beats a simultaneous tick
    @(negedge clk);
    bus_addr = A_CNT; bus_wdata = 100; bus_wr = 1'b1; tick_en = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; tick_en = 1'b0;
    rd(A_CNT, v); check("R2 load wins over tick", v, 100);

    // R5: upper enable bits dropped
    wr(A_IE, 32'hFFFF_FFFF);
    rd(A_IE, v); check("R5 enable width", v, 32'h0000_0FFF);

    // R3: exhaustive sweep of match values across channels
    for (int m = 0; m < 256; m++) begin
      int ch;
      ch = m % NC;
      wr(8'(ch * 4), 32'(m));
      wr(A_IE, 32'(1 << ch));
      wr(A_CNT, 32'((m - 2) & 8'hFF));
      tick();
      rd(A_ST, v); check("R3 no status one tick early", v, 0);
      tick();
      rd(A_ST, v); check("R3 status on match", v, 32'(1 << ch));
      check("R3 irq on match", 32'(irq_o), 32'(1 << ch));
      wr(A_ST, 32'(1 << ch));
      rd(A_ST, v); check("R6 clear by writing one", v, 0);
    end

    // R4: disabled channel stays quiet
    wr(A_IE, 0); wr(8'h00, 50); wr(A_CNT, 49); tick();
    rd(A_ST, v); check("R4 disabled status", v, 0);
    check("R4 disabled irq", 32'(irq_o), 0);

    // R6: zero writes keep the bit; set wins over clear
    wr(A_IE, 1); wr(A_CNT, 49); tick();
    wr(A_ST, 0); wr(A_ST, 2);
    rd(A_ST, v); check("R6 zero write keeps bit", v, 1);
    wr(A_ST, 1);
    wr(8'h00, 70); wr(A_CNT, 69);
    @(negedge clk);
    bus_addr = A_ST; bus_wdata = 1; bus_wr = 1'b1; tick_en = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; tick_en = 1'b0;
    rd(A_ST, v); check("R6 set beats clear", v, 1);
    wr(A_ST, 1);

    // R9: match at zero after wrap
    wr(8'h04, 0); wr(A_IE, 2); wr(A_CNT, 254); tick();
    rd(A_ST, v); check("R9 before wrap", v, 0);
    tick();
    rd(A_CNT, v); check("R9 wrapped count", v, 0);
    rd(A_ST, v); check("R9 match at zero", v, 2);
    wr(A_ST, 2);
    // R9: two matches over two periods
    wr(8'h08, 5); wr(A_IE, 4); wr(A_CNT, 0);
    seen = 0;
    for (int t = 0; t < 512; t++) begin
      tick();
      if (irq_o[2]) begin seen++; wr(A_ST, 4); end
    end
    check("R9 matches per two periods", 32'(seen), 2);

    // R10: unmapped offsets
    rd(A_IE, v);
    wr(8'h20, 32'hFFFF); wr(8'h11, 7);
    rd(8'h20, v); check("R10 unmapped read", v, 0);
    rd(8'h11, v); check("R10 unaligned read", v, 0);
    rd(A_CNT, v); check("R10 counter untouched", v, 0);
    rd(A_IE, v); check("R10 enable untouched", v, 4);

    // R7: unarmed watchdog stays silent
    wr(A_IE, 0); wr(8'h0C, 30); wr(A_CNT, 29); tick();
    check("R7 no request while unarmed", 32'(rst_req_o), 0);
    // R8: arm is set-only
    wr(A_WD, 1); wr(A_WD, 0);
    rd(A_WD, v); check("R8 arm sticky", v, 1);
    // R7: armed match gives one-cycle request with interrupt disabled
    wr(A_CNT, 29); tick();
    check("R7 request on match", 32'(rst_req_o), 1);
    @(negedge clk);
    check("R7 request one cycle", 32'(rst_req_o), 0);
    rd(A_ST, v); check("R4 watchdog channel status off", v, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  localparam logic [7:0] A_LIST [8] = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h10, 8'h14, 8'h18, 8'h1C};
endmodule